// File: doc/BRIEF.md
# ADC Conversion Autosequencer

This block drives one external analog-to-digital converter core. It steps through a table of sixteen conversion slots. Each slot names one of sixteen input channels. For every slot the block issues a one-cycle start with the slot's channel number, waits for the core's done pulse and stores the returned sample in the result register that belongs to that slot. One session runs up to sixteen conversions.

The sequencer works in one of two modes. In split mode it is two independent eight-slot sequencers. Sequencer A owns slots 0–7 and sequencer B owns slots 8–15, and each has its own start triggers. In cascaded mode sequencer A alone walks all sixteen slots. The triggers are a software start, two PWM event inputs and an external pin. At the end of each sequence the block can raise a per-sequencer interrupt flag, either on every end-of-sequence or on every second one. It reports busy flags, slot pointers and a conversion counter. The sequencer either stops after each sequence and resumes from where it left off, or restarts on its own.

Top module: `adc_autoseq`

## Requirements
- R1: Each accepted trigger runs (effective maximum + 1) conversions on consecutive slots, starting at the sequencer's pointer. For every conversion `conv_start` pulses for one cycle and `conv_chan` carries the slot's select, which for slot k is `chan_sel[4k+3:4k]`. The `conv_data` sampled with `conv_done` is stored in `results[12k+11:12k]`. `conv_done` is ignored when no conversion is outstanding.
- R2: In split mode sequencer A uses slots 0–7 with the effective maximum `max_conv_a[2:0]`, and its pointer wraps from 7 to 0. Sequencer B uses slots 8–15 with `max_conv_b`. `ptr_b` is its local index 0–7 (slot 8 + `ptr_b`) and wraps from 7 to 0.
- R3: In cascaded mode sequencer A uses slots 0–15 with the 4-bit `max_conv_a`, and its pointer wraps from 15 to 0. Sequencer B never becomes busy.
- R4: Sequencer A is triggered by `sw_start_a`, by `pwm_trig_a` when `pwm_a_en` is 1, by `ext_trig` when `ext_en` is 1, and in cascaded mode also by `pwm_trig_b` when `pwm_b_en` is 1. In split mode sequencer B is triggered by `sw_start_b` or by `pwm_trig_b` when `pwm_b_en` is 1. A disabled source has no effect.
- R5: With `cont_run` at 0, `busy` clears at the end of a sequence and the pointer is left on the slot after the last one converted. The next trigger resumes from there.
- R6: With `cont_run` at 1, the pointer returns to the sequencer's first slot at the end of a sequence. A new sequence then starts without a trigger and `busy` stays 1.
- R7: A pulse on `seq_rst_a` or `seq_rst_b` while that sequencer is idle sets its pointer to 0 and clears its end-of-sequence toggle.
- R8: If both sequencers are triggered in the same cycle in split mode, all of A's conversions run first and then all of B's. B shows busy while it waits.
- R9: A trigger that arrives while its sequencer is busy has no effect: the sequence runs only its own conversions and no extra sequence follows.
- R10: At each end of a sequence the `eos_buf` bit toggles. With the interrupt enabled, the flag is set on every end of sequence in mode 0 (`int_mode`=0). In mode 1 it is set only on an end of sequence that finds `eos_buf` at 1. With the interrupt disabled the flag is never set.
- R11: A pulse on `int_clr_a` or `int_clr_b` clears that flag. If a set and a clear fall in the same cycle, the set wins.
- R12: After reset every busy flag, pointer, interrupt flag, toggle, counter and result is 0. `conv_cnt` counts the conversions finished in the sequence in progress and reads 0 whenever both sequencers are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cascade_mode | input | 1 | 1 = one 16-slot sequencer, 0 = two 8-slot sequencers |
| cont_run | input | 1 | Restart automatically after each end of sequence |
| max_conv_a | input | 4 | Conversions minus one for sequencer A |
| max_conv_b | input | 3 | Conversions minus one for sequencer B |
| chan_sel | input | 64 | Channel select of slot k in bits 4k+3:4k |
| sw_start_a | input | 1 | Software start pulse, sequencer A |
| sw_start_b | input | 1 | Software start pulse, sequencer B |
| pwm_trig_a | input | 1 | PWM event A |
| pwm_trig_b | input | 1 | PWM event B |
| ext_trig | input | 1 | External start pulse |
| pwm_a_en | input | 1 | Enable for PWM event A |
| pwm_b_en | input | 1 | Enable for PWM event B |
| ext_en | input | 1 | Enable for the external start |
| seq_rst_a | input | 1 | Pointer reset pulse, sequencer A |
| seq_rst_b | input | 1 | Pointer reset pulse, sequencer B |
| int_en_a | input | 1 | Interrupt enable, sequencer A |
| int_en_b | input | 1 | Interrupt enable, sequencer B |
| int_mode_a | input | 1 | 0 = every end of sequence, 1 = every second, A |
| int_mode_b | input | 1 | 0 = every end of sequence, 1 = every second, B |
| int_clr_a | input | 1 | Interrupt flag clear pulse, A |
| int_clr_b | input | 1 | Interrupt flag clear pulse, B |
| conv_start | output | 1 | One-cycle start to the converter core |
| conv_chan | output | 4 | Channel for the conversion being started |
| conv_done | input | 1 | Conversion finished, data valid |
| conv_data | input | 12 | Converted sample |
| busy_a | output | 1 | Sequencer A busy or waiting for the core |
| busy_b | output | 1 | Sequencer B busy or waiting for the core |
| ptr_a | output | 4 | Sequencer A slot pointer |
| ptr_b | output | 3 | Sequencer B local slot pointer |
| conv_cnt | output | 4 | Conversions finished in the running sequence |
| int_flag_a | output | 1 | Interrupt flag, sequencer A |
| int_flag_b | output | 1 | Interrupt flag, sequencer B |
| eos_buf_a | output | 1 | End-of-sequence toggle, A |
| eos_buf_b | output | 1 | End-of-sequence toggle, B |
| results | output | 192 | Result of slot k in bits 12k+11:12k |

## Verification
The assertions assume that the mode bit, the maximum-conversion fields and the channel table hold still while a sequencer is busy. They also assume that the converter answers each start with exactly one done pulse. The bench changes the configuration only after both busy flags have dropped. Its converter model returns one done pulse, 0 to 3 cycles after each start it sees, and never raises done on its own. Random rounds draw the channel tables, sequence lengths, trigger sources and interrupt modes inside these limits. Directed cases cover the wrap points, simultaneous triggers, the retrigger while busy and continuous run.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic {PH_IDLE, PH_WAIT} seq_phase_e;
  typedef enum logic {OWN_A, OWN_B} seq_owner_e;
endpackage

// File: rtl/adc_seq_irq.sv
module adc_seq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic eos,
  input  logic seq_clr,
  input  logic int_en,
  input  logic int_mode,
  input  logic int_clr,
  output logic int_flag,
  output logic eos_buf
);
  logic flag_q, flag_d, ebuf_q, ebuf_d, set_now;

  always_comb begin
    set_now = eos && int_en && (!int_mode || ebuf_q);
    flag_d  = flag_q;
    if (int_clr) flag_d = 1'b0;
    if (set_now) flag_d = 1'b1;
    ebuf_d = ebuf_q;
    if (seq_clr) ebuf_d = 1'b0;
    if (eos)     ebuf_d = !ebuf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ebuf_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ebuf_q <= ebuf_d;
    end
  end

  assign int_flag = flag_q;
  assign eos_buf  = ebuf_q;

  // R10
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(eos && int_en));
  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clr && !eos) |=> !flag_q);
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
  parameter int NSLOT = 16,
  parameter int DW    = 12,
  localparam int PW   = $clog2(NSLOT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PW-1:0]       wr_idx,
  input  logic [DW-1:0]       wr_data,
  output logic [NSLOT*DW-1:0] results
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [DW-1:0] res_q;
    logic          hit;
    assign hit = wr_en && (wr_idx == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   res_q <= '0;
      else if (hit) res_q <= wr_data;
    end
    assign results[g*DW +: DW] = res_q;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int CHW   = 4,
  localparam int PW   = $clog2(NSLOT),
  localparam int HALF = NSLOT / 2,
  localparam int PWB  = $clog2(HALF)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cascade,
  input  logic                 cont_run,
  input  logic [PW-1:0]        max_a,
  input  logic [PWB-1:0]       max_b,
  input  logic [NSLOT*CHW-1:0] chan_sel,
  input  logic                 trig_a,
  input  logic                 trig_b,
  input  logic                 rst_a,
  input  logic                 rst_b,
  input  logic                 conv_done,
  output logic                 conv_start,
  output logic [CHW-1:0]       conv_chan,
  output logic                 busy_a,
  output logic                 busy_b,
  output logic [PW-1:0]        ptr_a,
  output logic [PWB-1:0]       ptr_b,
  output logic [PW-1:0]        conv_cnt,
  output logic                 eos_a,
  output logic                 eos_b,
  output logic                 seq_clr_a,
  output logic                 seq_clr_b,
  output logic                 wr_en,
  output logic [PW-1:0]        wr_idx
);
  localparam logic [PW-1:0] BASE_B = PW'(HALF);

  seq_phase_e       phase_q, phase_d;
  seq_owner_e       owner_q, owner_d;
  logic             busy_a_q, busy_a_d, busy_b_q, busy_b_d;
  logic [PW-1:0]    ptr_a_q, ptr_a_d, cnt_q, cnt_d;
  logic [PWB-1:0]   ptr_b_q, ptr_b_d;
  logic             start_q, start_d;
  logic [CHW-1:0]   chan_q, chan_d;

  logic [PW-1:0]    max_eff_a, nxt_a, abs_b, nxt_abs_b;
  logic [PWB-1:0]   lo_nxt_a, nxt_b;
  logic             last_a, last_b;

  function automatic logic [CHW-1:0] pick(input logic [PW-1:0] idx);
    return chan_sel[CHW*int'(idx) +: CHW];
  endfunction

  // wrap points and sequence lengths for the active mode
  always_comb begin
    lo_nxt_a  = ptr_a_q[PWB-1:0] + 1'b1;
    nxt_a     = cascade ? (ptr_a_q + 1'b1) : {{(PW-PWB){1'b0}}, lo_nxt_a};
    max_eff_a = cascade ? max_a : {{(PW-PWB){1'b0}}, max_a[PWB-1:0]};
    nxt_b     = ptr_b_q + 1'b1;
    abs_b     = BASE_B + {{(PW-PWB){1'b0}}, ptr_b_q};
    nxt_abs_b = BASE_B + {{(PW-PWB){1'b0}}, nxt_b};
    last_a    = (cnt_q == max_eff_a);
    last_b    = (cnt_q == {{(PW-PWB){1'b0}}, max_b});
  end

  always_comb begin
    phase_d  = phase_q;
    owner_d  = owner_q;
    busy_a_d = busy_a_q;
    busy_b_d = busy_b_q;
    ptr_a_d  = ptr_a_q;
    ptr_b_d  = ptr_b_q;
    cnt_d    = cnt_q;
    start_d  = 1'b0;
    chan_d   = chan_q;
    eos_a    = 1'b0;
    eos_b    = 1'b0;
    wr_en    = 1'b0;
    wr_idx   = (owner_q == OWN_A) ? ptr_a_q : abs_b;

    seq_clr_a = rst_a && !busy_a_q;
    seq_clr_b = rst_b && !busy_b_q;
    if (seq_clr_a) ptr_a_d = '0;
    if (seq_clr_b) ptr_b_d = '0;
    if (trig_a && !busy_a_q) busy_a_d = 1'b1;
    if (trig_b && !busy_b_q) busy_b_d = 1'b1;

    unique case (phase_q)
      PH_IDLE: begin
        if (busy_a_q) begin
          owner_d = OWN_A;
          phase_d = PH_WAIT;
          start_d = 1'b1;
          chan_d  = pick(ptr_a_q);
        end else if (busy_b_q) begin
          owner_d = OWN_B;
          phase_d = PH_WAIT;
          start_d = 1'b1;
          chan_d  = pick(abs_b);
        end
      end
      PH_WAIT: begin
        if (conv_done) begin
          wr_en = 1'b1;
          if (owner_q == OWN_A) begin
            if (last_a) begin
              eos_a    = 1'b1;
              cnt_d    = '0;
              phase_d  = PH_IDLE;
              busy_a_d = cont_run;
              ptr_a_d  = cont_run ? '0 : nxt_a;
            end else begin
              cnt_d   = cnt_q + 1'b1;
              ptr_a_d = nxt_a;
              start_d = 1'b1;
              chan_d  = pick(nxt_a);
            end
          end else begin
            if (last_b) begin
              eos_b    = 1'b1;
              cnt_d    = '0;
              phase_d  = PH_IDLE;
              busy_b_d = cont_run;
              ptr_b_d  = cont_run ? '0 : nxt_b;
            end else begin
              cnt_d   = cnt_q + 1'b1;
              ptr_b_d = nxt_b;
              start_d = 1'b1;
              chan_d  = pick(nxt_abs_b);
            end
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      owner_q  <= OWN_A;
      busy_a_q <= 1'b0;
      busy_b_q <= 1'b0;
      ptr_a_q  <= '0;
      ptr_b_q  <= '0;
      cnt_q    <= '0;
      start_q  <= 1'b0;
      chan_q   <= '0;
    end else begin
      phase_q  <= phase_d;
      owner_q  <= owner_d;
      busy_a_q <= busy_a_d;
      busy_b_q <= busy_b_d;
      ptr_a_q  <= ptr_a_d;
      ptr_b_q  <= ptr_b_d;
      cnt_q    <= cnt_d;
      start_q  <= start_d;
      chan_q   <= chan_d;
    end
  end

  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign busy_a     = busy_a_q;
  assign busy_b     = busy_b_q;
  assign ptr_a      = ptr_a_q;
  assign ptr_b      = ptr_b_q;
  assign conv_cnt   = cnt_q;

  // R1
  start_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (busy_a_q || busy_b_q));
  // R3
  casc_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_b_q) |-> $past(!cascade));
  // R4
  trig_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_a_q) |-> $past(trig_a));
  // R12
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_a_q && !busy_b_q) |-> (cnt_q == '0));
  // R8
  a_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && $past(phase_q == PH_IDLE) && $past(busy_a_q)) |-> (owner_q == OWN_A));
endmodule

// File: rtl/adc_autoseq.sv
module adc_autoseq #(
  parameter int NSLOT = 16,
  parameter int CHW   = 4,
  parameter int DW    = 12,
  localparam int PW   = $clog2(NSLOT),
  localparam int PWB  = $clog2(NSLOT / 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cascade_mode,
  input  logic                 cont_run,
  input  logic [PW-1:0]        max_conv_a,
  input  logic [PWB-1:0]       max_conv_b,
  input  logic [NSLOT*CHW-1:0] chan_sel,
  input  logic                 sw_start_a,
  input  logic                 sw_start_b,
  input  logic                 pwm_trig_a,
  input  logic                 pwm_trig_b,
  input  logic                 ext_trig,
  input  logic                 pwm_a_en,
  input  logic                 pwm_b_en,
  input  logic                 ext_en,
  input  logic                 seq_rst_a,
  input  logic                 seq_rst_b,
  input  logic                 int_en_a,
  input  logic                 int_en_b,
  input  logic                 int_mode_a,
  input  logic                 int_mode_b,
  input  logic                 int_clr_a,
  input  logic                 int_clr_b,
  output logic                 conv_start,
  output logic [CHW-1:0]       conv_chan,
  input  logic                 conv_done,
  input  logic [DW-1:0]        conv_data,
  output logic                 busy_a,
  output logic                 busy_b,
  output logic [PW-1:0]        ptr_a,
  output logic [PWB-1:0]       ptr_b,
  output logic [PW-1:0]        conv_cnt,
  output logic                 int_flag_a,
  output logic                 int_flag_b,
  output logic                 eos_buf_a,
  output logic                 eos_buf_b,
  output logic [NSLOT*DW-1:0]  results
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          trig_a, trig_b, eos_a, eos_b, clr_a, clr_b, wr_en;
  logic [PW-1:0] wr_idx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // trigger routing per mode
  always_comb begin
    trig_a = sw_start_a || (pwm_trig_a && pwm_a_en) || (ext_trig && ext_en)
             || (cascade_mode && pwm_trig_b && pwm_b_en);
    trig_b = !cascade_mode && (sw_start_b || (pwm_trig_b && pwm_b_en));
  end

  adc_seq_ctrl #(.NSLOT(NSLOT), .CHW(CHW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .cascade(cascade_mode), .cont_run(cont_run),
    .max_a(max_conv_a), .max_b(max_conv_b), .chan_sel(chan_sel),
    .trig_a(trig_a), .trig_b(trig_b), .rst_a(seq_rst_a), .rst_b(seq_rst_b),
    .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan),
    .busy_a(busy_a), .busy_b(busy_b), .ptr_a(ptr_a), .ptr_b(ptr_b),
    .conv_cnt(conv_cnt), .eos_a(eos_a), .eos_b(eos_b),
    .seq_clr_a(clr_a), .seq_clr_b(clr_b), .wr_en(wr_en), .wr_idx(wr_idx)
  );

  adc_seq_irq u_irq_a (
    .clk(clk), .rst_n(rst_int_n), .eos(eos_a), .seq_clr(clr_a),
    .int_en(int_en_a), .int_mode(int_mode_a), .int_clr(int_clr_a),
    .int_flag(int_flag_a), .eos_buf(eos_buf_a)
  );

  adc_seq_irq u_irq_b (
    .clk(clk), .rst_n(rst_int_n), .eos(eos_b), .seq_clr(clr_b),
    .int_en(int_en_b), .int_mode(int_mode_b), .int_clr(int_clr_b),
    .int_flag(int_flag_b), .eos_buf(eos_buf_b)
  );

  adc_seq_results #(.NSLOT(NSLOT), .DW(DW)) u_res (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(conv_data), .results(results)
  );
endmodule

// File: tb/test_adc_autoseq.sv
module test_adc_autoseq;
  localparam int NSLOT = 16;
  localparam int CHW   = 4;
  localparam int DW    = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cascade_mode, cont_run;
  logic [3:0] max_conv_a;
  logic [2:0] max_conv_b;
  logic [NSLOT*CHW-1:0] chan_sel;
  logic sw_start_a, sw_start_b, pwm_trig_a, pwm_trig_b, ext_trig;
  logic pwm_a_en, pwm_b_en, ext_en, seq_rst_a, seq_rst_b;
  logic int_en_a, int_en_b, int_mode_a, int_mode_b, int_clr_a, int_clr_b;
  logic conv_start, conv_done;
  logic [3:0] conv_chan;
  logic [DW-1:0] conv_data;
  logic busy_a, busy_b, int_flag_a, int_flag_b, eos_buf_a, eos_buf_b;
  logic [3:0] ptr_a, conv_cnt;
  logic [2:0] ptr_b;
  logic [NSLOT*DW-1:0] results;

  logic [3:0] sel_m [NSLOT];
  always_comb for (int i = 0; i < NSLOT; i++) chan_sel[i*CHW +: CHW] = sel_m[i];

  adc_autoseq i_adc_autoseq (.*);

  int checks = 0, fails = 0;
  int log_chan [4096];
  int log_data [4096];
  int log_n = 0;
  int exp_pa = 0, exp_pb = 0;
  bit exp_fa = 0, exp_fb = 0, exp_ea = 0, exp_eb = 0;

  // converter model: one done pulse 0..3 cycles after each start
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (conv_start) begin
        int d, lat;
        d   = int'($urandom % 4096);
        lat = int'($urandom % 4);
        log_chan[log_n] = int'(conv_chan);
        log_data[log_n] = d;
        log_n++;
        repeat (lat) @(negedge clk);
        conv_done = 1'b1;
        conv_data = DW'(d);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    tick(2);
    for (int i = 0; i < 5000 && (busy_a || busy_b); i++) tick(1);
  endtask

  function automatic int res_of(input int slot);
    return int'(results[slot*DW +: DW]);
  endfunction

  task automatic eos_model(input bit is_a);
    if (is_a) begin
      if (int_en_a && (!int_mode_a || exp_ea)) exp_fa = 1;
      exp_ea = !exp_ea;
    end else begin
      if (int_en_b && (!int_mode_b || exp_eb)) exp_fb = 1;
      exp_eb = !exp_eb;
    end
  endtask

  task automatic clear_trigs();
    sw_start_a = 0; sw_start_b = 0; pwm_trig_a = 0; pwm_trig_b = 0; ext_trig = 0;
  endtask

  // src_a: 0 software, 1 PWM A, 2 external, 3 PWM B (cascaded); src_b: 0 software, 1 PWM B
  task automatic run(input bit do_a, input bit do_b, input int src_a, input int src_b,
                     input bit retrig);
    int na, nb, base, size_a, seen_b;
    size_a = cascade_mode ? 16 : 8;
    na = do_a ? (cascade_mode ? int'(max_conv_a) : int'(max_conv_a[2:0])) + 1 : 0;
    nb = do_b ? int'(max_conv_b) + 1 : 0;
    base = log_n;
    seen_b = 0;
    if (do_a) begin
      case (src_a)
        0: sw_start_a = 1;
        1: begin pwm_a_en = 1; pwm_trig_a = 1; end
        2: begin ext_en = 1; ext_trig = 1; end
        default: begin pwm_b_en = 1; pwm_trig_b = 1; end
      endcase
    end
    if (do_b) begin
      if (src_b == 0) sw_start_b = 1;
      else begin pwm_b_en = 1; pwm_trig_b = 1; end
    end
    tick(1);
    clear_trigs();
    tick(1);
    if (do_a && do_b) check(busy_b == 1'b1, "R8 B pending", int'(busy_b), 1);
    if (retrig) begin
      tick(2);
      if (src_a == 0) sw_start_a = 1; else if (src_a == 2) ext_trig = 1; else pwm_trig_a = 1;
      tick(1);
      clear_trigs();
    end
    tick(1);
    for (int i = 0; i < 5000 && (busy_a || busy_b); i++) begin
      if (busy_b) seen_b = 1;
      tick(1);
    end
    tick(3);
    check(log_n - base == na + nb, retrig ? "R9 count" : "R1 count", log_n - base, na + nb);
    if (cascade_mode) check(seen_b == 0, "R3 B idle", seen_b, 0);
    for (int k = 0; k < na; k++) begin
      int slot = (exp_pa + k) % size_a;
      check(log_chan[base+k] == int'(sel_m[slot]), "R1 chan A", log_chan[base+k], int'(sel_m[slot]));
      check(res_of(slot) == log_data[base+k], "R1 result A", res_of(slot), log_data[base+k]);
    end
    for (int k = 0; k < nb; k++) begin
      int slot = 8 + (exp_pb + k) % 8;
      check(log_chan[base+na+k] == int'(sel_m[slot]), "R8 chan B order", log_chan[base+na+k], int'(sel_m[slot]));
      check(res_of(slot) == log_data[base+na+k], "R2 result B", res_of(slot), log_data[base+na+k]);
    end
    if (do_a) begin exp_pa = (exp_pa + na) % size_a; eos_model(1); end
    if (do_b) begin exp_pb = (exp_pb + nb) % 8; eos_model(0); end
    check(int'(ptr_a) == exp_pa, "R5 ptr A", int'(ptr_a), exp_pa);
    check(int'(ptr_b) == exp_pb, "R2 ptr B", int'(ptr_b), exp_pb);
    check(conv_cnt == 4'd0, "R12 cnt idle", int'(conv_cnt), 0);
    check(int_flag_a == exp_fa, "R10 flag A", int'(int_flag_a), int'(exp_fa));
    check(int_flag_b == exp_fb, "R10 flag B", int'(int_flag_b), int'(exp_fb));
    check(eos_buf_a == exp_ea && eos_buf_b == exp_eb, "R10 toggles",
          int'({eos_buf_a, eos_buf_b}), int'({exp_ea, exp_eb}));
  endtask

  task automatic reset_ptrs();
    seq_rst_a = 1; seq_rst_b = 1;
    tick(1);
    seq_rst_a = 0; seq_rst_b = 0;
    tick(1);
    exp_pa = 0; exp_pb = 0; exp_ea = 0; exp_eb = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int base, na;
    void'($urandom(32'd2718));
    rst_n = 0; cascade_mode = 0; cont_run = 0; max_conv_a = 0; max_conv_b = 0;
    clear_trigs();
    pwm_a_en = 0; pwm_b_en = 0; ext_en = 0; seq_rst_a = 0; seq_rst_b = 0;
    int_en_a = 0; int_en_b = 0; int_mode_a = 0; int_mode_b = 0; int_clr_a = 0; int_clr_b = 0;
    for (int i = 0; i < NSLOT; i++) sel_m[i] = 4'($urandom);
    tick(3);
    rst_n = 1;
    tick(4);

    // R12 reset state
    check(!busy_a && !busy_b && !conv_start, "R12 idle after reset", int'({busy_a, busy_b}), 0);
    check(ptr_a == 0 && ptr_b == 0 && conv_cnt == 0, "R12 pointers", int'(ptr_a), 0);
    check(!int_flag_a && !int_flag_b && !eos_buf_a && !eos_buf_b, "R12 flags", int'(int_flag_a), 0);
    check(results == '0, "R12 results", res_of(0), 0);

    // R1 R2 R10: split mode, 6 conversions, then wrap 6,7,0..3
    int_en_a = 1;
    max_conv_a = 4'd5;
    run(1, 0, 0, 0, 0);
    int_clr_a = 1; tick(1); int_clr_a = 0; tick(1);
    exp_fa = 0;
    check(int_flag_a == 1'b0, "R11 clear A", int'(int_flag_a), 0);
    run(1, 0, 2, 0, 0);
    check(ptr_a == 4'd4, "R2 wrap A", int'(ptr_a), 4);

    // R4 disabled PWM source ignored
    pwm_a_en = 0; base = log_n;
    pwm_trig_a = 1; tick(1); pwm_trig_a = 0; tick(4);
    check(!busy_a && log_n == base, "R4 disabled pwm", log_n - base, 0);
    // R4 enabled PWM source, R9 retrigger ignored
    run(1, 0, 1, 0, 1);

    // R8 R10 mode 1 on B: simultaneous triggers twice
    int_en_b = 1; int_mode_b = 1; max_conv_b = 3'd4; max_conv_a = 4'd2;
    run(1, 1, 0, 1, 0);
    check(int_flag_b == 1'b0, "R10 first eos no flag", int'(int_flag_b), 0);
    run(1, 1, 0, 0, 0);
    check(int_flag_b == 1'b1, "R10 second eos flag", int'(int_flag_b), 1);

    // R7 pointer reset while idle
    reset_ptrs();
    check(ptr_a == 0 && ptr_b == 0 && !eos_buf_a && !eos_buf_b, "R7 seq reset",
          int'(ptr_a) + int'(ptr_b), 0);

    // R6 continuous run: second sequence restarts at slot 0
    max_conv_a = 4'd2; na = 3; cont_run = 1; base = log_n;
    sw_start_a = 1; tick(1); sw_start_a = 0;
    for (int i = 0; i < 2000 && log_n < base + na + 1; i++) tick(1);
    check(busy_a == 1'b1, "R6 busy held", int'(busy_a), 1);
    cont_run = 0;
    wait_idle(); tick(3);
    check(log_n - base == 2 * na, "R6 count", log_n - base, 2 * na);
    check(log_chan[base+na] == int'(sel_m[0]), "R6 restart slot", log_chan[base+na], int'(sel_m[0]));
    for (int k = 0; k < na; k++)
      check(res_of(k) == log_data[base+na+k], "R6 result", res_of(k), log_data[base+na+k]);
    eos_model(1); eos_model(1); exp_pa = na;
    check(int'(ptr_a) == exp_pa, "R5 ptr after cont", int'(ptr_a), exp_pa);

    // R3 cascaded: 11 conversions, then 11..15,0..5
    cascade_mode = 1; reset_ptrs();
    max_conv_a = 4'd10;
    run(1, 0, 3, 0, 0);
    run(1, 0, 2, 0, 0);
    check(ptr_a == 4'd6, "R3 wrap cascade", int'(ptr_a), 6);
    base = log_n;
    sw_start_b = 1; tick(1); sw_start_b = 0; tick(4);
    check(!busy_b && log_n == base, "R3 B start ignored", log_n - base, 0);
    cascade_mode = 0; reset_ptrs();

    // random rounds in split mode
    for (int r = 0; r < 30; r++) begin
      bit da, db;
      for (int i = 0; i < NSLOT; i++) sel_m[i] = 4'($urandom);
      max_conv_a = 4'($urandom);
      max_conv_b = 3'($urandom);
      int_mode_a = 1'($urandom);
      int_mode_b = 1'($urandom);
      da = 1'($urandom); db = 1'($urandom);
      if (!da && !db) da = 1;
      run(da, db, int'($urandom % 3), int'($urandom % 2), 0);
    end
    finish_run();
  end
endmodule